// File: doc/BRIEF.md
# Byte-Serial CCITT CRC Accumulator

This block keeps a running 16-bit cyclic redundancy check over a stream of bytes, using the generator x^16 + x^12 + x^5 + 1. It sits on a simple processor bus and exposes two registers. The first is a 16-bit accumulator, which software seeds with any start value and later reads back as the finished code. The second is an 8-bit input register. Each byte written to the input register is folded into the accumulator without any further command.

Each byte is processed least-significant bit first with the reflected constant 8408h. The work is split over two clock cycles, four bits per cycle. While an update is running, the block raises a busy flag. A second byte offered during the first of those cycles is held off with a wait signal and is taken in the second cycle, so a stream sustains one byte every two cycles. The accumulator is written through two byte lanes. Any write to it cancels an update that is in progress.

Top module: `crc_ccitt_acc`

## Requirements
- R1: An update applies eight reflected CCITT steps to the accumulator, taking the byte's bits from bit 0 upward: feedback = acc[0] xor data bit, acc = acc >> 1, then xor with 8408h if feedback is 1. From an accumulator of 0000h, the byte 01h gives 1189h.
- R2: A write with bus_sel = 0 (accumulator) and bus_be = 2'b11 loads all 16 bits of bus_wdata, for any value from 0000h to FFFFh. The value reads back in the cycle after the write edge.
- R3: On an accumulator write, bus_be[0] enables bits 7:0 and bus_be[1] enables bits 15:8. A lane whose enable is low keeps its previous contents.
- R4: A write with bus_sel = 1 (input register) that is accepted at clock edge k sets crc_busy after edge k. The updated code is readable after edge k+2, and crc_busy is low then unless another byte was accepted.
- R5: The input register reads back the last accepted byte in bus_rdata[7:0], with the upper bits zero. An input write uses only bus_wdata[7:0] and ignores bus_be.
- R6: An input write offered in the first busy cycle raises bus_wait and is not taken at that edge. The same write held into the second busy cycle is accepted with no byte lost, so back-to-back bytes each cost two cycles.
- R7: Any accumulator write, whatever its lane enables, cancels an update that is in progress. crc_busy is low after that edge, and no remaining step is applied to the written value.
- R8: After reset, crc_busy and bus_wait are low, and both registers read 0000h.
- R9: bus_rdata is zero whenever bus_rd is low. With bus_rd high, it shows the register chosen by bus_sel in the same cycle.
- R10: After any seed and any byte stream, the accumulator equals the bit-serial code of that stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_sel | input | 1 | Register select: 0 accumulator, 1 input byte |
| bus_be | input | 2 | Byte-lane enables for accumulator writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when bus_rd is low |
| bus_wait | output | 1 | Input write must be held; not taken this edge |
| crc_busy | output | 1 | Byte update in progress |

## Verification
An accumulator write appears at the read port one cycle after its edge. An accepted byte appears exactly two edges after the edge that took it, and crc_busy is high in the two cycles between those edges. The bench drives inputs on the falling edge and reads on the next falling edge, so it counts rising edges exactly. It checks busy after the first and second edges and compares the code only after the second. Stalls are counted while the write is held, so the two-cycle pacing of back-to-back bytes is checked directly. A bench function computes the bit-serial code for random seeds and streams.

// File: rtl/crc_pkg.sv
package crc_pkg;
    // Register select encoding on bus_sel
    typedef enum logic {
        SEL_ACC  = 1'b0,
        SEL_BYTE = 1'b1
    } crc_sel_e;
endpackage

// File: rtl/crc_nibble_unit.sv
// Combinational chain of reflected CRC steps, one per input bit, LSB first.
module crc_nibble_unit #(
    parameter int          CRC_W  = 16,
    parameter int          STEP_W = 4,
    parameter logic [15:0] POLY   = 16'h8408
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [STEP_W-1:0] dat_in,
    output logic [CRC_W-1:0]  crc_out
);
    logic [STEP_W:0][CRC_W-1:0] chain;

    assign chain[0] = crc_in;

    for (genvar i = 0; i < STEP_W; i++) begin : g_bit
        logic fb;
        assign fb           = chain[i][0] ^ dat_in[i];
        assign chain[i+1]   = (chain[i] >> 1) ^ (fb ? CRC_W'(POLY) : '0);
    end

    assign crc_out = chain[STEP_W];
endmodule

// File: rtl/crc_bus_decode.sv
// Turns bus strobes into register actions and the stall indication.
module crc_bus_decode
    import crc_pkg::*;
#(
    parameter int PH_W    = 1,
    parameter int LAST_PH = 1
) (
    input  logic            bus_wr,
    input  logic            bus_sel,
    input  logic            busy_q,
    input  logic [PH_W-1:0] phase_q,
    output logic            seed_wr,
    output logic            byte_acc,
    output logic            bus_wait
);
    logic byte_req;
    logic can_take;

    always_comb begin
        seed_wr  = bus_wr && (crc_sel_e'(bus_sel) == SEL_ACC);
        byte_req = bus_wr && (crc_sel_e'(bus_sel) == SEL_BYTE);
        // a new byte may enter when idle or while the last step retires
        can_take = !busy_q || (phase_q == PH_W'(LAST_PH));
        byte_acc = byte_req && can_take;
        bus_wait = byte_req && !can_take;
    end
endmodule

// File: rtl/crc_read_mux.sv
// Read data selection; drives zero when no read is strobed.
module crc_read_mux
    import crc_pkg::*;
#(
    parameter int CRC_W = 16,
    parameter int IN_W  = 8
) (
    input  logic             bus_rd,
    input  logic             bus_sel,
    input  logic [CRC_W-1:0] acc_q,
    input  logic [IN_W-1:0]  byte_q,
    output logic [CRC_W-1:0] bus_rdata
);
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (crc_sel_e'(bus_sel) == SEL_ACC) bus_rdata = acc_q;
            else                                bus_rdata = CRC_W'(byte_q);
        end
    end
endmodule

// File: rtl/crc_ccitt_acc.sv
module crc_ccitt_acc #(
    parameter int          CRC_W  = 16,
    parameter int          IN_W   = 8,
    parameter int          STEP_W = 4,
    parameter logic [15:0] POLY   = 16'h8408
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_sel,
    input  logic [CRC_W/8-1:0] bus_be,
    input  logic [CRC_W-1:0]   bus_wdata,
    output logic [CRC_W-1:0]   bus_rdata,
    output logic               bus_wait,
    output logic               crc_busy
);
    localparam int LANES     = CRC_W / 8;
    localparam int NUM_STEPS = IN_W / STEP_W;
    localparam int PH_W      = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;
    localparam int LAST_PH   = NUM_STEPS - 1;

    typedef struct packed {
        logic [CRC_W-1:0] acc;
        logic [IN_W-1:0]  in_byte;
        logic             busy;
        logic [PH_W-1:0]  phase;
    } state_t;

    state_t st_d, st_q;

    logic                             seed_wr;
    logic                             byte_acc;
    logic [NUM_STEPS-1:0][STEP_W-1:0] nibs;
    logic [STEP_W-1:0]                step_nib;
    logic [CRC_W-1:0]                 step_out;

    crc_bus_decode #(
        .PH_W    (PH_W),
        .LAST_PH (LAST_PH)
    ) dec_i (
        .bus_wr   (bus_wr),
        .bus_sel  (bus_sel),
        .busy_q   (st_q.busy),
        .phase_q  (st_q.phase),
        .seed_wr  (seed_wr),
        .byte_acc (byte_acc),
        .bus_wait (bus_wait)
    );

    assign nibs     = st_q.in_byte;
    assign step_nib = nibs[st_q.phase];

    crc_nibble_unit #(
        .CRC_W  (CRC_W),
        .STEP_W (STEP_W),
        .POLY   (POLY)
    ) step_i (
        .crc_in  (st_q.acc),
        .dat_in  (step_nib),
        .crc_out (step_out)
    );

    crc_read_mux #(
        .CRC_W (CRC_W),
        .IN_W  (IN_W)
    ) rd_i (
        .bus_rd    (bus_rd),
        .bus_sel   (bus_sel),
        .acc_q     (st_q.acc),
        .byte_q    (st_q.in_byte),
        .bus_rdata (bus_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (seed_wr) begin
            // seeding wins: lanes load from the bus, any update is dropped
            for (int l = 0; l < LANES; l++) begin
                if (bus_be[l]) st_d.acc[l*8 +: 8] = bus_wdata[l*8 +: 8];
            end
            st_d.busy  = 1'b0;
            st_d.phase = '0;
        end else begin
            if (st_q.busy) begin
                st_d.acc = step_out;
                if (st_q.phase == PH_W'(LAST_PH)) begin
                    st_d.busy  = 1'b0;
                    st_d.phase = '0;
                end else begin
                    st_d.phase = st_q.phase + 1'b1;
                end
            end
            if (byte_acc) begin
                st_d.in_byte = bus_wdata[IN_W-1:0];
                st_d.busy    = 1'b1;
                st_d.phase   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crc_busy = st_q.busy;

    // ---------------- assertions ----------------
    p_accept_sets_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_acc |=> crc_busy);

    p_last_step_retires_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_busy && st_q.phase == PH_W'(LAST_PH) && !bus_wr) |=> !crc_busy);

    p_wait_only_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> crc_busy);

    p_stalled_byte_not_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |=> $stable(st_q.in_byte));

    p_seed_full_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_wr && (&bus_be)) |=> (st_q.acc == $past(bus_wdata)));

    p_seed_aborts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seed_wr |=> !crc_busy);

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        p_lane_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (seed_wr && !bus_be[l]) |=> (st_q.acc[l*8 +: 8] == $past(st_q.acc[l*8 +: 8])));
    end
endmodule

// File: tb/crc_ccitt_acc_tb_top.sv
module crc_ccitt_acc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_sel = 1'b0;
    logic [1:0]  bus_be = 2'b00;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_wait;
    logic        crc_busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 4 ns period

    crc_ccitt_acc dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_sel   (bus_sel),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_wait  (bus_wait),
        .crc_busy  (crc_busy)
    );

    function automatic logic [15:0] ref_byte(logic [15:0] c, logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ b[i];
            r = r >> 1;
            if (fb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // All tasks begin and end just after a falling edge.
    task automatic rd(logic sel, output logic [15:0] v);
        bus_rd = 1'b1; bus_sel = sel;
        #1 v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic seed(logic [15:0] v, logic [1:0] be);
        bus_wr = 1'b1; bus_sel = 1'b0; bus_be = be; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic put_byte(logic [7:0] b, output int stalls);
        stalls = 0;
        bus_wr = 1'b1; bus_sel = 1'b1;
        bus_be = 2'($urandom); bus_wdata = {8'($urandom), b};
        #1;
        while (bus_wait) begin
            stalls++;
            @(negedge clk); #1;
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, exp;
        int st;
        void'($urandom(32'h1c0ffee));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state
        #1;
        check(crc_busy == 1'b0, "R8", "busy after reset", crc_busy, 0);
        check(bus_wait == 1'b0, "R8", "wait after reset", bus_wait, 0);
        rd(1'b0, v); check(v == 16'h0, "R8", "acc after reset", v, 0);
        rd(1'b1, v); check(v == 16'h0, "R8", "byte reg after reset", v, 0);
        @(negedge clk);

        // R1/R4: 01h from 0000h, timing of busy and result
        seed(16'h0000, 2'b11);
        put_byte(8'h01, st);
        check(crc_busy == 1'b1, "R4", "busy after accept edge", crc_busy, 1);
        @(negedge clk);
        check(crc_busy == 1'b1, "R4", "busy in second cycle", crc_busy, 1);
        @(negedge clk);
        check(crc_busy == 1'b0, "R4", "busy after two cycles", crc_busy, 0);
        rd(1'b0, v); check(v == 16'h1189, "R1", "crc of 01h", v, 16'h1189);

        // R2: full seed of extremes
        seed(16'hFFFF, 2'b11);
        rd(1'b0, v); check(v == 16'hFFFF, "R2", "seed FFFFh", v, 16'hFFFF);
        seed(16'h0000, 2'b11);
        rd(1'b0, v); check(v == 16'h0000, "R2", "seed 0000h", v, 0);

        // R3: byte lanes
        seed(16'hABCD, 2'b11);
        seed(16'h1234, 2'b01);
        rd(1'b0, v); check(v == 16'hAB34, "R3", "low lane only", v, 16'hAB34);
        seed(16'h5600, 2'b10);
        rd(1'b0, v); check(v == 16'h5634, "R3", "high lane only", v, 16'h5634);
        seed(16'h9999, 2'b00);
        rd(1'b0, v); check(v == 16'h5634, "R3", "no lane", v, 16'h5634);

        // R9: no read strobe gives zero
        bus_rd = 1'b0; bus_sel = 1'b0; #1;
        check(bus_rdata == 16'h0, "R9", "rdata idle", bus_rdata, 0);
        @(negedge clk);

        // R5: byte register readback, upper data and lanes ignored
        seed(16'h1D0F, 2'b11);
        put_byte(8'hA5, st);
        repeat (2) @(negedge clk);
        rd(1'b1, v); check(v == 16'h00A5, "R5", "byte readback", v, 16'h00A5);
        rd(1'b0, v); exp = ref_byte(16'h1D0F, 8'hA5);
        check(v == exp, "R5", "crc ignores upper data", v, exp);

        // R6: back-to-back bytes stall exactly once
        seed(16'h4321, 2'b11);
        put_byte(8'h3C, st);
        put_byte(8'hC3, st);
        check(st == 1, "R6", "stall cycles", st, 1);
        repeat (2) @(negedge clk);
        rd(1'b0, v); exp = ref_byte(ref_byte(16'h4321, 8'h3C), 8'hC3);
        check(v == exp, "R6", "no byte lost", v, exp);
        check(crc_busy == 1'b0, "R6", "idle after stream", crc_busy, 0);

        // R7: abort in first and second update cycle
        seed(16'h0000, 2'b11);
        put_byte(8'hFF, st);
        seed(16'hBEEF, 2'b11);
        check(crc_busy == 1'b0, "R7", "busy cleared (first cycle)", crc_busy, 0);
        @(negedge clk);
        rd(1'b0, v); check(v == 16'hBEEF, "R7", "seed kept (first cycle)", v, 16'hBEEF);
        put_byte(8'h77, st);
        @(negedge clk);
        seed(16'h1357, 2'b11);
        check(crc_busy == 1'b0, "R7", "busy cleared (second cycle)", crc_busy, 0);
        @(negedge clk);
        rd(1'b0, v); check(v == 16'h1357, "R7", "seed kept (second cycle)", v, 16'h1357);
        put_byte(8'h10, st);
        seed(16'h2222, 2'b01);
        @(negedge clk);
        check(crc_busy == 1'b0, "R7", "lane-limited write aborts", crc_busy, 0);

        // R10: random seeds and streams against bit-serial model
        for (int t = 0; t < 40; t++) begin
            logic [15:0] s = 16'($urandom);
            logic [7:0]  b = 8'h00;
            int len = 1 + int'($urandom % 16);
            exp = s;
            seed(s, 2'b11);
            for (int k = 0; k < len; k++) begin
                b = 8'($urandom);
                exp = ref_byte(exp, b);
                put_byte(b, st);
            end
            repeat (2) @(negedge clk);
            rd(1'b0, v); check(v == exp, "R10", "random stream crc", v, exp);
            rd(1'b1, v); check(v == {8'h00, b}, "R5", "last byte readback", v, {8'h00, b});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule